// File: doc/BRIEF.md
# Self-Clocking Serial Byte Receiver

This block receives 8N1 asynchronous serial data without being told the bit rate. After reset it is unlocked and hunts for a calibration character, the value 0x80. That character's start bit and its seven low data bits form one low run eight bit-times long. The block counts system clock cycles over that run and shifts the count right by three to get the full bit period. It shifts the count right by four to get the half bit period. It then raises its lock output and receives ordinary bytes at that rate, sampling each bit near its middle.

A received byte is presented on a holding register together with a one-cycle strobe. A stop bit that reads low gives a one-cycle framing-error strobe instead. If the line stays low for longer than ten bit periods while locked, the block reports a line break, drops lock and hunts for a fresh calibration character. The sender may then come back at a different rate. Both measured periods are exported so that a neighbouring transmitter can use the same timing.

Top module: `autobaud_rx`

## Requirements
- R1: While reset is asserted and right after it, `locked_o`, `done_o`, `ferr_o` and `break_o` are 0, and `data_o`, `full_bit_o` and `half_bit_o` are 0.
- R2: While unlocked, a low run of N cycles on the synchronized line, with N ≥ 16, sets `full_bit_o` to N>>3 and `half_bit_o` to N>>4 and raises `locked_o`.
- R3: A low run shorter than 16 cycles while unlocked is discarded, and `locked_o` stays 0.
- R4: The calibration counter stops at 2^CNT_W−1 instead of wrapping, so a very long run gives `full_bit_o` = (2^CNT_W−1)>>3.
- R5: While locked, a falling edge whose line reads high again one half period later is a false start and produces no strobe. `data_o` is unchanged.
- R6: Data bits are taken least-significant first at the half period plus k full periods after the start edge. `done_o` is a one-cycle pulse, due 2 + half + 9·full clock edges after the first edge that captures the low start bit into the first synchronizer flop, and `data_o` shows the byte from then on.
- R7: A stop bit that reads low gives a one-cycle `ferr_o` pulse at the same point where `done_o` would have come. `done_o` stays 0 and `data_o` keeps its previous value.
- R8: Frames sent back to back with no idle time between the stop bit and the next start bit are all received.
- R9: While locked, a line held low for more than 10·full cycles gives a one-cycle `break_o` pulse and drops `locked_o`. A new calibration character then sets new periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | 8 | Last byte received with a valid stop bit |
| done_o | output | 1 | One-cycle strobe when a byte is received |
| ferr_o | output | 1 | One-cycle strobe when a stop bit reads low |
| break_o | output | 1 | One-cycle strobe when a line break is detected |
| locked_o | output | 1 | Bit rate has been measured |
| full_bit_o | output | CNT_W | Measured full bit period in clock cycles |
| half_bit_o | output | CNT_W | Measured half bit period in clock cycles |

## Verification
Every frame the driver sends is queued together with the clock cycle in which its strobe is due. That cycle is computed from the bit period the bench chose: 3 + P/2 + 9·P cycles after the negative edge where the start bit is driven, counting the two synchronizer flops and the strobe register. The monitor samples on negative edges. It treats a strobe in any other cycle, a strobe with an empty queue, or a strobe of the wrong kind as a mismatch, so false starts and ignored pulses are checked by the absence of output. The lock state, the periods and the break strobe are checked after calibration runs and breaks have had several bit-times to settle.

// File: rtl/ab_pkg.sv
package ab_pkg;
  typedef enum logic [2:0] {
    S_HUNT,
    S_MEAS,
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP
  } rx_state_t;
endpackage

// File: rtl/ab_sync.sv
module ab_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);
  logic ff1_q, ff2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q  <= 1'b1;
      ff2_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      ff1_q  <= rx_i;
      ff2_q  <= ff1_q;
      prev_q <= ff2_q;
    end
  end

  assign line_o = ff2_q;
  assign fall_o = prev_q & ~ff2_q;

  AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> $past(line_o)); // R6
endmodule

// File: rtl/ab_break.sv
module ab_break #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             locked_i,
  input  logic [CNT_W-1:0] full_i,
  output logic             brk_o
);
  localparam int LW = CNT_W + 4;
  localparam logic [LW-1:0] LMAX = {LW{1'b1}};

  logic [LW-1:0] low_q, low_d;
  logic [LW-1:0] limit;
  logic          brk_q, brk_d;

  assign limit = ({4'b0, full_i} << 3) + ({4'b0, full_i} << 1);

  always_comb begin
    low_d = low_q;
    brk_d = 1'b0;
    if (!locked_i || line_i) begin
      low_d = '0;
    end else begin
      if (low_q != LMAX) low_d = low_q + 1'b1;
      if (low_q == limit) brk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
      brk_q <= 1'b0;
    end else begin
      low_q <= low_d;
      brk_q <= brk_d;
    end
  end

  assign brk_o = brk_q;

  AST_BRK_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> $past(locked_i)); // R9
  AST_BRK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |=> !brk_o); // R9
endmodule

// File: rtl/ab_core.sv
module ab_core
  import ab_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             fall_i,
  input  logic             brk_i,
  output logic [7:0]       data_o,
  output logic             done_o,
  output logic             ferr_o,
  output logic             locked_o,
  output logic [CNT_W-1:0] full_o,
  output logic [CNT_W-1:0] half_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_CNT);

  rx_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       data_q, data_d;
  logic             done_q, done_d;
  logic             ferr_q, ferr_d;
  logic             lock_q, lock_d;
  logic [CNT_W-1:0] full_q, full_d;
  logic [CNT_W-1:0] half_q, half_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    data_d  = data_q;
    done_d  = 1'b0;
    ferr_d  = 1'b0;
    lock_d  = lock_q;
    full_d  = full_q;
    half_d  = half_q;
    if (brk_i) begin
      state_d = S_HUNT;
      lock_d  = 1'b0;
    end else begin
      unique case (state_q)
        S_HUNT: begin
          if (fall_i) begin
            cnt_d   = CNT_W'(1);
            state_d = S_MEAS;
          end
        end
        S_MEAS: begin
          if (line_i) begin
            if (cnt_q >= CNT_MIN) begin
              full_d  = cnt_q >> 3;
              half_d  = cnt_q >> 4;
              lock_d  = 1'b1;
              state_d = S_IDLE;
            end else begin
              state_d = S_HUNT;
            end
          end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_IDLE: begin
          if (fall_i) begin
            cnt_d   = half_q - 1'b1;
            state_d = S_START;
          end
        end
        S_START: begin
          if (cnt_q == '0) begin
            if (!line_i) begin
              cnt_d   = full_q - 1'b1;
              bit_d   = 3'd0;
              state_d = S_DATA;
            end else begin
              state_d = S_IDLE;
            end
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        S_DATA: begin
          if (cnt_q == '0) begin
            sh_d  = {line_i, sh_q[7:1]};
            cnt_d = full_q - 1'b1;
            if (bit_q == 3'd7) state_d = S_STOP;
            else               bit_d   = bit_q + 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        S_STOP: begin
          if (cnt_q == '0) begin
            if (line_i) begin
              data_d = sh_q;
              done_d = 1'b1;
            end else begin
              ferr_d = 1'b1;
            end
            state_d = S_IDLE;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: state_d = S_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HUNT;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
      lock_q  <= 1'b0;
      full_q  <= '0;
      half_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      data_q  <= data_d;
      done_q  <= done_d;
      ferr_q  <= ferr_d;
      lock_q  <= lock_d;
      full_q  <= full_d;
      half_q  <= half_d;
    end
  end

  assign data_o   = data_q;
  assign done_o   = done_q;
  assign ferr_o   = ferr_q;
  assign locked_o = lock_q;
  assign full_o   = full_q;
  assign half_o   = half_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_FERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_o |=> !ferr_o); // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && ferr_o)); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_o) |-> done_o); // R7
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_MEAS && cnt_q == CNT_MAX && !line_i) |=> (cnt_q == CNT_MAX)); // R4
  AST_LOCK_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> (full_o >= (CNT_MIN >> 3))); // R3
  AST_BREAK_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |=> !locked_o); // R9
endmodule

// File: rtl/autobaud_rx.sv
module autobaud_rx #(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  output logic [7:0]       data_o,
  output logic             done_o,
  output logic             ferr_o,
  output logic             break_o,
  output logic             locked_o,
  output logic [CNT_W-1:0] full_bit_o,
  output logic [CNT_W-1:0] half_bit_o
);
  logic line, fall, brk, locked;
  logic [CNT_W-1:0] full;

  ab_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_i),
    .line_o (line),
    .fall_o (fall)
  );

  ab_break #(.CNT_W(CNT_W)) u_break (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (line),
    .locked_i (locked),
    .full_i   (full),
    .brk_o    (brk)
  );

  ab_core #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (line),
    .fall_i   (fall),
    .brk_i    (brk),
    .data_o   (data_o),
    .done_o   (done_o),
    .ferr_o   (ferr_o),
    .locked_o (locked),
    .full_o   (full),
    .half_o   (half_bit_o)
  );

  assign locked_o   = locked;
  assign full_bit_o = full;
  assign break_o    = brk;
endmodule

// File: tb/sim_autobaud_rx.sv
module sim_autobaud_rx;
  localparam int CLK_NS = 10;
  localparam int CW     = 12;

  typedef struct {
    int     data;
    longint due;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx = 1'b1;
  logic [7:0]    data_o;
  logic          done_o, ferr_o, break_o, locked_o;
  logic [CW-1:0] full_bit_o, half_bit_o;

  exp_t   q[$];
  longint cyc = 0;
  int     n_cmp = 0;
  int     n_bad = 0;
  int     brk_seen = 0;
  logic [7:0] last_good = 8'h00;
  bit     finished = 1'b0;

  autobaud_rx #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx),
    .data_o(data_o), .done_o(done_o), .ferr_o(ferr_o), .break_o(break_o),
    .locked_o(locked_o), .full_bit_o(full_bit_o), .half_bit_o(half_bit_o)
  );

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as strobes appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (break_o) brk_seen++;
      if (done_o || ferr_o) begin
        if (q.size() == 0) begin
          chk(1'b0, done_o ? "R5 unexpected done" : "R7 unexpected ferr", longint'(data_o), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.due, "R6 strobe cycle", cyc, e.due);
          if (e.data < 0) begin
            chk(ferr_o && !done_o, "R7 ferr expected", longint'(done_o), 0);
            chk(data_o == last_good, "R7 data held", longint'(data_o), longint'(last_good));
          end else begin
            chk(done_o && !ferr_o, "R6 done expected", longint'(ferr_o), 0);
            chk(data_o == e.data[7:0], "R6 byte LSB first", longint'(data_o), longint'(e.data));
            last_good = data_o;
          end
        end
      end
    end
  end

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  // drive one frame with bit period p; queue the expected outcome
  task automatic send(input logic [7:0] b, input logic stop, input int p);
    exp_t e;
    e.data = stop ? int'(b) : -1;
    e.due  = cyc + 3 + p/2 + 9*p;
    q.push_back(e);
    hold(1'b0, p);
    for (int i = 0; i < 8; i++) hold(b[i], p);
    hold(stop, p);
  endtask

  task automatic drain(input string tag);
    repeat (40) @(negedge clk);
    chk(q.size() == 0, tag, q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(locked_o == 0 && done_o == 0 && ferr_o == 0 && break_o == 0, "R1 flags in reset",
        {locked_o, done_o, ferr_o, break_o}, 0);
    chk(data_o == 0 && full_bit_o == 0 && half_bit_o == 0, "R1 regs in reset", data_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(locked_o == 0, "R1 unlocked after reset", locked_o, 0);

    // R3 too short
    hold(1'b0, 10);
    hold(1'b1, 40);
    chk(locked_o == 0, "R3 short run rejected", locked_o, 0);

    // R2 calibrate at 32 cycles per bit
    hold(1'b0, 256);
    hold(1'b1, 64);
    chk(locked_o == 1, "R2 locked", locked_o, 1);
    chk(full_bit_o == 32, "R2 full period", full_bit_o, 32);
    chk(half_bit_o == 16, "R2 half period", half_bit_o, 16);

    // R6 R8 back to back
    send(8'hA5, 1'b1, 32);
    send(8'h3C, 1'b1, 32);
    send(8'h01, 1'b1, 32);
    send(8'hFE, 1'b1, 32);
    hold(1'b1, 64);
    drain("R8 back-to-back all received");

    // R5 false start
    hold(1'b0, 6);
    hold(1'b1, 100);
    chk(data_o == 8'hFE, "R5 data after false start", data_o, 8'hFE);
    send(8'h5A, 1'b1, 32);
    hold(1'b1, 64);
    drain("R5 receive after false start");

    // R7 bad stop bit
    send(8'h55, 1'b0, 32);
    hold(1'b1, 64);
    drain("R7 framing error seen");
    chk(data_o == 8'h5A, "R7 data unchanged", data_o, 8'h5A);

    // R9 break, then recalibrate at 48
    begin
      exp_t e;
      e.data = -1;
      e.due = cyc + 3 + 16 + 9*32;
      q.push_back(e);
    end
    hold(1'b0, 384);
    hold(1'b1, 64);
    chk(brk_seen == 1, "R9 break pulse", brk_seen, 1);
    chk(locked_o == 0, "R9 unlocked by break", locked_o, 0);
    drain("R9 ferr before break");
    hold(1'b0, 384);
    hold(1'b1, 96);
    chk(locked_o == 1 && full_bit_o == 48, "R9 relock full period", full_bit_o, 48);
    chk(half_bit_o == 24, "R9 relock half period", half_bit_o, 24);
    send(8'h69, 1'b1, 48);
    send(8'h96, 1'b1, 48);
    hold(1'b1, 96);
    drain("R9 bytes at new rate");

    // R4 saturation: break first, then a very long run
    begin
      exp_t e;
      e.data = -1;
      e.due = cyc + 3 + 24 + 9*48;
      q.push_back(e);
    end
    hold(1'b0, 600);
    hold(1'b1, 20);
    chk(brk_seen == 2, "R9 second break", brk_seen, 2);
    drain("R9 ferr before second break");
    hold(1'b0, 5000);
    hold(1'b1, 40);
    chk(locked_o == 1, "R4 locked after long run", locked_o, 1);
    chk(full_bit_o == ((1 << CW) - 1) >> 3, "R4 saturated full", full_bit_o, ((1 << CW) - 1) >> 3);
    chk(half_bit_o == ((1 << CW) - 1) >> 4, "R4 saturated half", half_bit_o, ((1 << CW) - 1) >> 4);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule